// File: doc/BRIEF.md
# Host Halfword Line-Transfer Port for Shared Word Memory

This block gives a host with a 16-bit I/O bus access to a 32-bit word memory that processor modules also use. The host works through four I/O-addressed registers: two that hold the word address, one data register and one control register. Data moves in line transfers. The host sets a start address once and then reads or writes the data register repeatedly. Each memory word is split into two halfwords, low half first. After the high half of a word has been handled, the word address steps forward by one.

A two-way arbiter shares the memory between the host side of the port and a single processor-side requester. Once granted, the memory stays with its owner for a fixed number of cycles, which is one complete word access. When both sides ask in the same idle cycle, the side granted less recently wins. The host waits on a ready flag, which stays low while the data access it has presented is queued or in progress. Through the control register the host can also send a one-cycle interrupt to any processor module.

Top module: `hostmem_port`

## Requirements
- R1: After reset the word address is 0, the halfword phase is low, `hst_ready` is 1, and `mem_en`, `prc_gnt` and `irq_out` are all 0.
- R2: Register select 0 reads and writes word-address bits 15:0. Select 1 holds address bits 17:16 in data bits 1:0. Writing either address register returns the halfword phase to low.
- R3: Writing the data register (select 2) in the low phase stores the halfword and completes with `hst_ready` high. It makes no memory access, and the phase becomes high.
- R4: Writing the data register in the high phase writes the 32-bit word {high, low} to the current address. The address then increments by one and the phase returns to low.
- R5: Reading the data register in the low phase fetches the word from memory and returns bits 15:0. The next read in the high phase returns bits 31:16 without a memory access, then increments the address and returns the phase to low.
- R6: While a data-register access that needs memory is waiting for or holding the grant, `hst_ready` stays 0. The transfer completes only in a cycle with `hst_ready` at 1.
- R7: The 18-bit word address wraps from 0x3FFFF to 0.
- R8: At most one of host and processor holds the memory at a time. When both request in the same idle cycle, the side granted less recently wins. The processor counts as most recent out of reset.
- R9: Every grant lasts exactly ACC_CYC cycles (default 2), with `mem_en` high for each of them. `prc_done` pulses in the last cycle of a processor grant, and `prc_rdata` is valid in that cycle.
- R10: Writing the control register (select 3) with bit 15 set and a target number T in bits 14:0 raises `irq_out[T]` for one cycle when T < N_PROC. Any other target, or bit 15 clear, raises nothing.
- R11: Reading the control register returns the halfword phase in bit 0 (0 means low), with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_sel | input | 1 | Host selects the port this cycle |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_reg | input | 2 | Register select: 0 addr low, 1 addr high, 2 data, 3 control |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data |
| hst_ready | output | 1 | Transfer completes in a cycle where this is 1 |
| prc_req | input | 1 | Processor memory request, held until `prc_done` |
| prc_we | input | 1 | Processor write enable |
| prc_addr | input | 18 | Processor word address |
| prc_wdata | input | 32 | Processor write data |
| prc_gnt | output | 1 | Processor holds the memory |
| prc_done | output | 1 | Last cycle of the processor access |
| prc_rdata | output | 32 | Processor read data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, registered one cycle after enable |
| irq_out | output | 4 | One interrupt line per processor module |

## Verification
A corrupted halfword phase appears as soon as the host reads the control register. It also shows up on the next data access: a memory cycle is issued when none was due, or a halfword comes back from the wrong half. A wrong address step appears on the address readback straight after the high half completes. It also appears as a word landing at the wrong location, which the next read of that line reveals. Arbiter state errors show within one contended request: the wrong side wins, or `mem_en` stays high for a number of cycles other than ACC_CYC. The bench counts memory-enable cycles and interrupt pulses per line to catch these within a few cycles.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  typedef enum logic [1:0] {
    RS_ADDR_LO = 2'd0,
    RS_ADDR_HI = 2'd1,
    RS_DATA    = 2'd2,
    RS_CTRL    = 2'd3
  } hreg_e;

  typedef enum logic {
    OWN_HOST = 1'b0,
    OWN_PROC = 1'b1
  } owner_e;
endpackage

// File: rtl/hmp_regs.sv
module hmp_regs
  import hmp_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int HW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        regsel,
  input  logic [HW-1:0]     wdata,
  output logic [HW-1:0]     rdata,
  output logic              ready,
  output logic              req,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [2*HW-1:0]   req_wdata,
  input  logic              done,
  input  logic [2*HW-1:0]   mem_rdata
);
  localparam int DW   = 2 * HW;
  localparam int AH_W = ADDR_W - HW;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              half_q, half_d;
  logic [DW-1:0]     rbuf_q, rbuf_d;
  logic [HW-1:0]     wlo_q, wlo_d;
  logic [HW-1:0]     whi_q, whi_d;
  logic              pend_q, pend_d;
  logic              pwe_q, pwe_d;
  logic              cmpl_q, cmpl_d;

  hreg_e rs;
  logic  is_wr, is_rd, is_data, need_mem, fire;

  assign rs       = hreg_e'(regsel);
  assign is_wr    = sel & wr;
  assign is_rd    = sel & rd & ~wr;
  assign is_data  = (rs == RS_DATA);
  assign need_mem = is_data & ((is_wr & half_q) | (is_rd & ~half_q));
  assign ready    = ~need_mem | cmpl_q;
  assign fire     = (is_wr | is_rd) & ready;

  always_comb begin
    addr_d = addr_q;
    half_d = half_q;
    rbuf_d = rbuf_q;
    wlo_d  = wlo_q;
    whi_d  = whi_q;
    pend_d = pend_q;
    pwe_d  = pwe_q;
    cmpl_d = cmpl_q;

    if (done) begin
      pend_d = 1'b0;
      cmpl_d = 1'b1;
      if (!pwe_q) rbuf_d = mem_rdata;
    end

    if (need_mem && !pend_q && !cmpl_q) begin
      pend_d = 1'b1;
      pwe_d  = is_wr;
      if (is_wr) whi_d = wdata;
    end

    if (fire) begin
      unique case (rs)
        RS_ADDR_LO: if (is_wr) begin
          addr_d[HW-1:0] = wdata;
          half_d = 1'b0;
          cmpl_d = 1'b0;
        end
        RS_ADDR_HI: if (is_wr) begin
          addr_d[ADDR_W-1:HW] = wdata[AH_W-1:0];
          half_d = 1'b0;
          cmpl_d = 1'b0;
        end
        RS_DATA: begin
          if (!half_q) begin
            if (is_wr) wlo_d = wdata;
            half_d = 1'b1;
            cmpl_d = 1'b0;
          end else begin
            addr_d = addr_q + ADDR_W'(1);
            half_d = 1'b0;
            cmpl_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      half_q <= 1'b0;
      rbuf_q <= '0;
      wlo_q  <= '0;
      whi_q  <= '0;
      pend_q <= 1'b0;
      pwe_q  <= 1'b0;
      cmpl_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      half_q <= half_d;
      rbuf_q <= rbuf_d;
      wlo_q  <= wlo_d;
      whi_q  <= whi_d;
      pend_q <= pend_d;
      pwe_q  <= pwe_d;
      cmpl_q <= cmpl_d;
    end
  end

  always_comb begin
    unique case (rs)
      RS_ADDR_LO: rdata = addr_q[HW-1:0];
      RS_ADDR_HI: rdata = HW'(addr_q[ADDR_W-1:HW]);
      RS_DATA:    rdata = half_q ? rbuf_q[DW-1:HW] : rbuf_q[HW-1:0];
      default:    rdata = HW'(half_q);
    endcase
  end

  assign req       = pend_q;
  assign req_we    = pwe_q;
  assign req_addr  = addr_q;
  assign req_wdata = {whi_q, wlo_q};

  // R6: a memory-needing access that is queued must hold the host off
  a_r6_stall_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && need_mem) |-> !ready);

  // R4 / R5 / R7: completing the high half steps the address by one, modulo the address width
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_data && half_q) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

  // R3: a low-half write never raises a memory request
  a_r3_low_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_data && is_wr && !half_q && !pend_q) |=> !pend_q);
endmodule

// File: rtl/hmp_arb.sv
module hmp_arb
  import hmp_pkg::*;
#(
  parameter int ACC_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_h,
  input  logic req_c,
  output logic gnt_h,
  output logic gnt_c,
  output logic done_h,
  output logic done_c,
  output logic own_c
);
  localparam int CW = $clog2(ACC_CYC + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(ACC_CYC - 1);

  logic      busy_q, busy_d;
  owner_e    own_q, own_d;
  owner_e    last_q, last_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic      fin;
  owner_e    pick;
  logic      start;

  assign fin = busy_q & (cnt_q == LAST_CNT);

  always_comb begin
    start = 1'b0;
    pick  = OWN_HOST;
    if (!busy_q) begin
      if (req_h && req_c) begin
        start = 1'b1;
        pick  = (last_q == OWN_PROC) ? OWN_HOST : OWN_PROC;
      end else if (req_h) begin
        start = 1'b1;
        pick  = OWN_HOST;
      end else if (req_c) begin
        start = 1'b1;
        pick  = OWN_PROC;
      end
    end
  end

  always_comb begin
    busy_d = busy_q;
    own_d  = own_q;
    last_d = last_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      own_d  = pick;
      last_d = pick;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (fin) busy_d = 1'b0;
      else     cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= OWN_HOST;
      last_q <= OWN_PROC;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      own_q  <= own_d;
      last_q <= last_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gnt_h  = busy_q & (own_q == OWN_HOST);
  assign gnt_c  = busy_q & (own_q == OWN_PROC);
  assign done_h = fin & (own_q == OWN_HOST);
  assign done_c = fin & (own_q == OWN_PROC);
  assign own_c  = (own_q == OWN_PROC);

  // R8: exclusive ownership
  a_r8_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_h && gnt_c));

  // R9: a grant keeps its owner until its final cycle
  a_r9_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> (busy_q && $stable(own_q)));

  // R8: a contended idle cycle goes to the side not granted last
  a_r8_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && req_h && req_c) |=> (busy_q && own_q != $past(last_q)));
endmodule

// File: rtl/hmp_irq.sv
module hmp_irq #(
  parameter int N_PROC = 4,
  parameter int HW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [HW-1:0]     wdata,
  output logic [N_PROC-1:0] irq
);
  logic [N_PROC-1:0] irq_q, irq_d;
  logic              raise;

  assign raise = stb & wdata[HW-1];

  for (genvar i = 0; i < N_PROC; i++) begin : g_line
    assign irq_d[i] = raise & (wdata[HW-2:0] == (HW-1)'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R10: at most one line fires
  a_r10_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_q));

  // R10: a line fires only after a control write with the raise bit set
  a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q != '0) |-> $past(stb && wdata[HW-1]));
endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
  import hmp_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int HW      = 16,
  parameter int N_PROC  = 4,
  parameter int ACC_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_sel,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [1:0]        hst_reg,
  input  logic [HW-1:0]     hst_wdata,
  output logic [HW-1:0]     hst_rdata,
  output logic              hst_ready,
  input  logic              prc_req,
  input  logic              prc_we,
  input  logic [ADDR_W-1:0] prc_addr,
  input  logic [2*HW-1:0]   prc_wdata,
  output logic              prc_gnt,
  output logic              prc_done,
  output logic [2*HW-1:0]   prc_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [2*HW-1:0]   mem_wdata,
  input  logic [2*HW-1:0]   mem_rdata,
  output logic [N_PROC-1:0] irq_out
);
  localparam int DW = 2 * HW;

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic              h_req, h_we, h_done, gnt_h, done_c, own_c;
  logic [ADDR_W-1:0] h_addr;
  logic [DW-1:0]     h_wdata;
  logic              ctrl_stb;

  hmp_regs #(.ADDR_W(ADDR_W), .HW(HW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync),
    .sel       (hst_sel),
    .wr        (hst_wr),
    .rd        (hst_rd),
    .regsel    (hst_reg),
    .wdata     (hst_wdata),
    .rdata     (hst_rdata),
    .ready     (hst_ready),
    .req       (h_req),
    .req_we    (h_we),
    .req_addr  (h_addr),
    .req_wdata (h_wdata),
    .done      (h_done),
    .mem_rdata (mem_rdata)
  );

  hmp_arb #(.ACC_CYC(ACC_CYC)) u_arb (
    .clk    (clk),
    .rst_n  (rst_sync),
    .req_h  (h_req),
    .req_c  (prc_req),
    .gnt_h  (gnt_h),
    .gnt_c  (prc_gnt),
    .done_h (h_done),
    .done_c (done_c),
    .own_c  (own_c)
  );

  assign ctrl_stb = hst_sel & hst_wr & (hreg_e'(hst_reg) == RS_CTRL);

  hmp_irq #(.N_PROC(N_PROC), .HW(HW)) u_irq (
    .clk   (clk),
    .rst_n (rst_sync),
    .stb   (ctrl_stb),
    .wdata (hst_wdata),
    .irq   (irq_out)
  );

  assign mem_en    = gnt_h | prc_gnt;
  assign mem_we    = mem_en & (own_c ? prc_we : h_we);
  assign mem_addr  = own_c ? prc_addr : h_addr;
  assign mem_wdata = own_c ? prc_wdata : h_wdata;
  assign prc_done  = done_c;
  assign prc_rdata = mem_rdata;

  // R9: processor completion only inside a processor grant
  a_r9_done_in_grant: assert property (@(posedge clk) disable iff (!rst_sync)
    prc_done |-> (prc_gnt && mem_en));

  // R1: nothing moves out of reset in the first released cycle
  a_r1_quiet_release: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(rst_sync) |-> (!mem_en && irq_out == '0));
endmodule

// File: tb/tb_hostmem_port.sv
module tb_hostmem_port;
  localparam int ACC = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_sel, hst_wr, hst_rd;
  logic [1:0]  hst_reg;
  logic [15:0] hst_wdata, hst_rdata;
  logic        hst_ready;
  logic        prc_req, prc_we;
  logic [17:0] prc_addr;
  logic [31:0] prc_wdata, prc_rdata;
  logic        prc_gnt, prc_done;
  logic        mem_en, mem_we;
  logic [17:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  irq_out;

  int checks = 0;
  int fails  = 0;
  int en_cnt = 0;
  int irq_cnt [4];
  logic [31:0] bmem [64];
  logic        armed = 1'b0;
  int          winner = -1;

  always #10 clk = ~clk;

  hostmem_port dut (
    .clk(clk), .rst_n(rst_n),
    .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_reg(hst_reg),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_ready(hst_ready),
    .prc_req(prc_req), .prc_we(prc_we), .prc_addr(prc_addr), .prc_wdata(prc_wdata),
    .prc_gnt(prc_gnt), .prc_done(prc_done), .prc_rdata(prc_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq_out(irq_out)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr[5:0]] <= mem_wdata;
      mem_rdata <= bmem[mem_addr[5:0]];
    end
  end

  always @(negedge clk) begin
    if (mem_en) en_cnt++;
    for (int i = 0; i < 4; i++) if (irq_out[i]) irq_cnt[i]++;
    if (armed && winner < 0 && mem_en) winner = prc_gnt ? 1 : 0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] r, input logic [15:0] d);
    @(negedge clk);
    hst_sel = 1'b1; hst_wr = 1'b1; hst_rd = 1'b0; hst_reg = r; hst_wdata = d;
    #1;
    while (!hst_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    hst_sel = 1'b0; hst_wr = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] r, output logic [15:0] d);
    @(negedge clk);
    hst_sel = 1'b1; hst_wr = 1'b0; hst_rd = 1'b1; hst_reg = r;
    #1;
    while (!hst_ready) begin @(negedge clk); #1; end
    d = hst_rdata;
    @(posedge clk); #1;
    hst_sel = 1'b0; hst_rd = 1'b0;
  endtask

  task automatic prd(input logic [17:0] a, output logic [31:0] d);
    prc_req = 1'b1; prc_we = 1'b0; prc_addr = a;
    @(negedge clk); #1;
    while (!prc_done) begin @(negedge clk); #1; end
    d = prc_rdata;
    prc_req = 1'b0;
  endtask

  // {is_read, reg, data, expected}
  localparam logic [34:0] VEC [15] = '{
    {1'b0, 2'd0, 16'h0010, 16'h0000},
    {1'b0, 2'd1, 16'h0000, 16'h0000},
    {1'b0, 2'd2, 16'h1111, 16'h0000},
    {1'b0, 2'd2, 16'h2222, 16'h0000},
    {1'b0, 2'd2, 16'h3333, 16'h0000},
    {1'b0, 2'd2, 16'h4444, 16'h0000},
    {1'b1, 2'd0, 16'h0000, 16'h0012},
    {1'b0, 2'd0, 16'h0010, 16'h0000},
    {1'b1, 2'd3, 16'h0000, 16'h0000},
    {1'b1, 2'd2, 16'h0000, 16'h1111},
    {1'b1, 2'd3, 16'h0000, 16'h0001},
    {1'b1, 2'd2, 16'h0000, 16'h2222},
    {1'b1, 2'd2, 16'h0000, 16'h3333},
    {1'b1, 2'd2, 16'h0000, 16'h4444},
    {1'b1, 2'd0, 16'h0000, 16'h0012}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r16;
    logic [31:0] r32;
    int e0;
    for (int i = 0; i < 64; i++) bmem[i] = 32'h0;
    for (int i = 0; i < 4; i++) irq_cnt[i] = 0;
    mem_rdata = '0;
    hst_sel = 0; hst_wr = 0; hst_rd = 0; hst_reg = 0; hst_wdata = 0;
    prc_req = 0; prc_we = 0; prc_addr = 0; prc_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    check("R1 ready", hst_ready, 1);
    check("R1 mem_en", mem_en, 0);
    check("R1 prc_gnt", prc_gnt, 0);
    check("R1 irq", irq_out, 0);
    hrd(2'd0, r16); check("R1 addr lo", r16, 0);
    hrd(2'd3, r16); check("R1 phase", r16, 0);

    // Vector table: R2 R4 R5 R11
    for (int v = 0; v < 15; v++) begin
      if (VEC[v][34]) begin
        hrd(VEC[v][33:32], r16);
        check($sformatf("R2/R5/R11 vec%0d", v), r16, VEC[v][15:0]);
      end else hwr(VEC[v][33:32], VEC[v][31:16]);
    end
    check("R4 word0", bmem[6'h10], 32'h2222_1111);
    check("R4 word1", bmem[6'h11], 32'h4444_3333);

    // R3 / R9 memory cycles per halfword write
    hwr(2'd0, 16'h0005);
    e0 = en_cnt;
    hwr(2'd2, 16'h5A5A);
    repeat (3) @(negedge clk);
    check("R3 low write no mem", en_cnt - e0, 0);
    hrd(2'd3, r16); check("R3 phase high", r16, 1);
    e0 = en_cnt;
    hwr(2'd2, 16'hA5A5);
    @(negedge clk);
    check("R9 grant length", en_cnt - e0, ACC);
    // R5 high read makes no access
    hwr(2'd0, 16'h0005);
    hrd(2'd2, r16); check("R5 low", r16, 16'h5A5A);
    e0 = en_cnt;
    hrd(2'd2, r16); check("R5 high", r16, 16'hA5A5);
    @(negedge clk);
    check("R5 high no mem", en_cnt - e0, 0);
    // R2 address write resets phase
    hrd(2'd2, r16);
    hwr(2'd0, 16'h0006);
    hrd(2'd3, r16); check("R2 phase reset", r16, 0);

    // R7 wrap
    hwr(2'd0, 16'hFFFF); hwr(2'd1, 16'h0003);
    hrd(2'd1, r16); check("R2 addr hi", r16, 3);
    hwr(2'd2, 16'h0A0A); hwr(2'd2, 16'h0B0B);
    hrd(2'd0, r16); check("R7 wrap lo", r16, 0);
    hrd(2'd1, r16); check("R7 wrap hi", r16, 0);
    check("R7 word at top", bmem[63], 32'h0B0B_0A0A);

    // R9 processor read
    prd(18'h10, r32); check("R9 prc read", r32, 32'h2222_1111);

    // R8 contention round 1: processor granted last -> host wins
    hwr(2'd0, 16'h0020); hwr(2'd1, 16'h0000);
    hwr(2'd2, 16'hAAAA);
    winner = -1; armed = 1'b1;
    fork
      hwr(2'd2, 16'hBBBB);
      begin @(posedge clk); @(negedge clk); #2; prd(18'h11, r32); end
    join
    armed = 1'b0;
    check("R8 round1 host first", winner, 0);
    check("R8 round1 prc data", r32, 32'h4444_3333);
    check("R4 contended word", bmem[6'h20], 32'hBBBB_AAAA);
    // host-only access so host is most recent
    hwr(2'd0, 16'h0020);
    hrd(2'd2, r16); check("R5 reread low", r16, 16'hAAAA);
    hrd(2'd2, r16); check("R5 reread high", r16, 16'hBBBB);
    hwr(2'd2, 16'hCCCC);
    winner = -1; armed = 1'b1;
    fork
      hwr(2'd2, 16'hDDDD);
      begin @(posedge clk); @(negedge clk); #2; prd(18'h10, r32); end
    join
    armed = 1'b0;
    check("R8 round2 processor first", winner, 1);
    check("R4 second contended word", bmem[6'h21], 32'hDDDD_CCCC);

    // R10 interrupts
    hwr(2'd3, 16'h8002);
    repeat (2) @(negedge clk);
    check("R10 target 2 one pulse", irq_cnt[2], 1);
    hwr(2'd3, 16'h8007);
    hwr(2'd3, 16'h0001);
    repeat (2) @(negedge clk);
    check("R10 ignored writes", irq_cnt[0] + irq_cnt[1] + irq_cnt[3], 0);
    check("R10 target 2 unchanged", irq_cnt[2], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule